// File: doc/BRIEF.md
# Instruction Cache Tag Controller with Eviction Hint

This block holds the tags and the replacement state of a set-associative instruction cache. It takes three kinds of request: a fetch lookup that asks whether a line is resident, a fill that installs a line returned by the next level, and an eviction hint. Software sends the hint to mark one resident line as no longer useful. The hint acts only on this cache. It sends nothing to other levels, needs no writeback and never stalls. The next fill that must replace a line in the hinted line's set takes the hinted line ahead of the normal policy's choice.

The normal policy is selected by a pin and is either true LRU or pseudo-random. The random choice comes from a 16-bit LFSR and needs no per-line metadata. Two saturating counters are brought out. One counts replacements whose victim was a hinted line. The other counts replacements whose victim came from the normal policy. The data array, coherence with other levels and prefetching are handled elsewhere.

The default geometry is 32 KiB with 8 ways and 64-byte lines, which gives 64 sets.

Top module: `ic_hint_ctrl`

## Requirements
- R1: An address splits into a line offset in bits [5:0], a set index in bits [11:6] and a tag in bits [31:12]. A lookup hits only when a valid way of the indexed set holds the same tag. The offset bits are ignored.
- R2: A lookup request sampled at a rising edge produces `lk_done` high, with `lk_hit` valid, in the cycle after the third rising edge. `lk_done` is low in every other cycle.
- R3: A fill whose line is absent installs the line in the lowest-numbered invalid way of its set, if the set has one. Filling an invalid way changes neither counter.
- R4: A hint whose line is resident marks that line. Lookup hits leave the mark in place. When a fill must evict a valid line and the set holds a marked line, the lowest-numbered marked way is evicted and `cnt_hint_repl` increments. A newly installed line is unmarked.
- R5: A hint whose line is not resident changes nothing: later lookups, victim choices and counters are the same as without the hint.
- R6: With `pol_rand`=0 and no marked line, the victim is the least recently used way. A lookup hit and a fill, whether it installs or re-fills a line, each make their way the most recently used.
- R7: With `pol_rand`=1 and no marked line, the victim is the way numbered by the low 3 bits of a 16-bit LFSR. The LFSR resets to 0xACE1 and advances on every fill to {s[14:0], s[15]^s[13]^s[12]^s[10]}. The victim uses the value held in the cycle of the fill.
- R8: Each policy-chosen eviction of a valid line increments `cnt_base_repl`. Both counters stop at their all-ones value and change only on the edge of a fill.
- R9: When a hint and a fill reach the same set in the same cycle, the hint is applied first, so a resident hinted line becomes that fill's victim.
- R10: A fill whose line is already resident replaces nothing and changes no counter. It only refreshes recency.
- R11: After reset every line is invalid, no line is marked, both counters read 0 and `lk_done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pol_rand | input | 1 | Base policy: 0 true LRU, 1 pseudo-random |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Lookup byte address |
| lk_done | output | 1 | Lookup result valid (3 cycles after the request) |
| lk_hit | output | 1 | Lookup hit when lk_done is high |
| fl_valid | input | 1 | Fill request |
| fl_addr | input | ADDR_W | Fill line address |
| ht_valid | input | 1 | Eviction hint request |
| ht_addr | input | ADDR_W | Hinted line address |
| cnt_hint_repl | output | CNT_W | Saturating count of hint-driven replacements |
| cnt_base_repl | output | CNT_W | Saturating count of policy-driven replacements |

## Verification
A lookup result is due exactly three rising edges after its request. The bench samples `lk_hit` at the falling edge after the third edge, and it also confirms that `lk_done` is still low one cycle earlier. Fills and hints take effect at the first edge, so the counters are compared at the following falling edge. Each operation finishes before the next one starts, which means every lookup sees tag and recency state that the bench model has already brought up to date. The same-cycle case of R9 is driven as a single operation, and the model resolves it with the hint first.

// File: rtl/ic_hint_pkg.sv
`timescale 1ns/1ps
package ic_hint_pkg;
  localparam int unsigned RND_W = 16;
  localparam logic [RND_W-1:0] RND_SEED = 16'hACE1;

  typedef enum logic {POL_LRU = 1'b0, POL_RAND = 1'b1} ic_pol_e;

  // Fibonacci shift with taps 16,14,13,11
  function automatic logic [RND_W-1:0] rnd_step(input logic [RND_W-1:0] s);
    return {s[RND_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction
endpackage

// File: rtl/ic_tag_array.sv
`timescale 1ns/1ps
module ic_tag_array #(
  parameter int SETS  = 64,
  parameter int WAYS  = 8,
  parameter int TAG_W = 20,
  parameter int IDX_W = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [IDX_W-1:0]            lk_idx,
  output logic [WAYS-1:0][TAG_W-1:0]  lk_tags,
  output logic [WAYS-1:0]             lk_vld,
  input  logic [IDX_W-1:0]            fl_idx,
  output logic [WAYS-1:0][TAG_W-1:0]  fl_tags,
  output logic [WAYS-1:0]             fl_vld,
  output logic [WAYS-1:0]             fl_flg,
  input  logic [IDX_W-1:0]            ht_idx,
  output logic [WAYS-1:0][TAG_W-1:0]  ht_tags,
  output logic [WAYS-1:0]             ht_vld,
  input  logic                        wr_en,
  input  logic [WAYS-1:0]             wr_oh,
  input  logic [TAG_W-1:0]            wr_tag,
  input  logic                        mark_en,
  input  logic [WAYS-1:0]             mark_oh
);
  logic [WAYS-1:0][TAG_W-1:0] tag_q [SETS];
  logic [WAYS-1:0]            vld_q [SETS];
  logic [WAYS-1:0]            flg_q [SETS];

  assign lk_tags = tag_q[lk_idx];
  assign lk_vld  = vld_q[lk_idx];
  assign fl_tags = tag_q[fl_idx];
  assign fl_vld  = vld_q[fl_idx];
  assign fl_flg  = flg_q[fl_idx];
  assign ht_tags = tag_q[ht_idx];
  assign ht_vld  = vld_q[ht_idx];

  always_ff @(posedge clk) begin
    for (int w = 0; w < WAYS; w++)
      if (wr_en && wr_oh[w]) tag_q[fl_idx][w] <= wr_tag;
  end

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic hit_wr, hit_mark;
    assign hit_wr   = wr_en && (fl_idx == IDX_W'(s));
    assign hit_mark = mark_en && (ht_idx == IDX_W'(s));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q[s] <= '0;
        flg_q[s] <= '0;
      end else begin
        if (hit_wr) vld_q[s] <= vld_q[s] | wr_oh;
        // mark first, then the install clears the replaced way
        flg_q[s] <= (flg_q[s] | (hit_mark ? mark_oh : '0)) & ~(hit_wr ? wr_oh : '0);
      end
    end
  end
endmodule

// File: rtl/ic_recency.sv
`timescale 1ns/1ps
module ic_recency #(
  parameter int SETS  = 64,
  parameter int WAYS  = 8,
  parameter int IDX_W = 6,
  parameter int WAY_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_en,
  input  logic [IDX_W-1:0] a_idx,
  input  logic [WAY_W-1:0] a_way,
  input  logic             b_en,
  input  logic [IDX_W-1:0] b_idx,
  input  logic [WAY_W-1:0] b_way,
  input  logic [IDX_W-1:0] q_idx,
  output logic [WAY_W-1:0] lru_way
);
  typedef logic [WAYS-1:0][WAY_W-1:0] row_t;
  row_t age_q [SETS];

  // rank 0 = most recent, WAYS-1 = least recent
  function automatic row_t touch(input row_t r, input logic [WAY_W-1:0] w);
    row_t n = r;
    for (int i = 0; i < WAYS; i++) begin
      if (WAY_W'(i) == w)  n[i] = '0;
      else if (r[i] < r[w]) n[i] = r[i] + 1'b1;
    end
    return n;
  endfunction

  for (genvar s = 0; s < SETS; s++) begin : g_set
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
      end else if (b_en && b_idx == IDX_W'(s)) begin
        age_q[s] <= touch(age_q[s], b_way);
      end else if (a_en && a_idx == IDX_W'(s)) begin
        age_q[s] <= touch(age_q[s], a_way);
      end
    end
  end

  always_comb begin
    lru_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (age_q[q_idx][w] == WAY_W'(WAYS-1)) lru_way = WAY_W'(w);
  end
endmodule

// File: rtl/ic_victim_pick.sv
`timescale 1ns/1ps
module ic_victim_pick #(
  parameter int WAYS  = 8,
  parameter int WAY_W = 3
) (
  input  logic [WAYS-1:0]  vld,
  input  logic [WAYS-1:0]  flg,
  input  logic [WAY_W-1:0] lru_way,
  input  logic [WAY_W-1:0] rnd_way,
  input  logic             use_rand,
  output logic [WAY_W-1:0] way,
  output logic             by_hint,
  output logic             evicts
);
  logic [WAY_W-1:0] free_way, flg_way;

  always_comb begin
    free_way = '0;
    flg_way  = '0;
    for (int w = WAYS-1; w >= 0; w--) begin
      if (!vld[w]) free_way = WAY_W'(w);
      if (flg[w])  flg_way  = WAY_W'(w);
    end
    evicts  = &vld;
    by_hint = 1'b0;
    if (!evicts)   way = free_way;
    else if (|flg) begin
      way     = flg_way;
      by_hint = 1'b1;
    end
    else if (use_rand) way = rnd_way;
    else               way = lru_way;
  end
endmodule

// File: rtl/ic_hint_ctrl.sv
`timescale 1ns/1ps
module ic_hint_ctrl
  import ic_hint_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CAPACITY   = 32768,
  parameter int LINE_BYTES = 64,
  parameter int WAYS       = 8,
  parameter int CNT_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pol_rand,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_done,
  output logic              lk_hit,
  input  logic              fl_valid,
  input  logic [ADDR_W-1:0] fl_addr,
  input  logic              ht_valid,
  input  logic [ADDR_W-1:0] ht_addr,
  output logic [CNT_W-1:0]  cnt_hint_repl,
  output logic [CNT_W-1:0]  cnt_base_repl
);
  localparam int SETS  = CAPACITY / (LINE_BYTES * WAYS);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
  localparam int WAY_W = $clog2(WAYS);

  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction
  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction
  function automatic logic [WAYS-1:0] match(input logic [WAYS-1:0][TAG_W-1:0] t,
                                            input logic [WAYS-1:0] v,
                                            input logic [TAG_W-1:0] k);
    logic [WAYS-1:0] m;
    for (int w = 0; w < WAYS; w++) m[w] = v[w] && (t[w] == k);
    return m;
  endfunction
  function automatic logic [WAY_W-1:0] enc(input logic [WAYS-1:0] m);
    logic [WAY_W-1:0] r = '0;
    for (int w = 0; w < WAYS; w++) if (m[w]) r = WAY_W'(w);
    return r;
  endfunction
  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] c);
    return (&c) ? c : c + 1'b1;
  endfunction

  logic [3*OFF_W-1:0] offsets_unused;
  assign offsets_unused = {lk_addr[OFF_W-1:0], fl_addr[OFF_W-1:0], ht_addr[OFF_W-1:0]};

  // lookup pipeline
  logic             s1_v, s2_v, s2_hit;
  logic [IDX_W-1:0] s1_idx;
  logic [TAG_W-1:0] s1_tag;
  logic [WAYS-1:0][TAG_W-1:0] lk_tags, fl_tags, ht_tags;
  logic [WAYS-1:0]  lk_vld, fl_vld, fl_flg, ht_vld;
  logic [WAYS-1:0]  lk_match, fl_match, ht_match, eff_flg;
  logic             lk_found, fl_present, ht_same;
  logic [IDX_W-1:0] fl_idx, ht_idx;
  logic [WAY_W-1:0] lru_way, vic_way, touch_way;
  logic             vic_by_hint, vic_evicts, wr_en;
  logic             evt_hint_repl, evt_base_repl;
  logic [RND_W-1:0] rnd_q;

  assign fl_idx = idx_of(fl_addr);
  assign ht_idx = idx_of(ht_addr);

  ic_tag_array #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .lk_idx(s1_idx), .lk_tags(lk_tags), .lk_vld(lk_vld),
    .fl_idx(fl_idx), .fl_tags(fl_tags), .fl_vld(fl_vld), .fl_flg(fl_flg),
    .ht_idx(ht_idx), .ht_tags(ht_tags), .ht_vld(ht_vld),
    .wr_en(wr_en), .wr_oh(WAYS'(1) << vic_way), .wr_tag(tag_of(fl_addr)),
    .mark_en(ht_valid && |ht_match), .mark_oh(ht_match)
  );

  assign lk_match   = match(lk_tags, lk_vld, s1_tag);
  assign lk_found   = s1_v && |lk_match;
  assign fl_match   = match(fl_tags, fl_vld, tag_of(fl_addr));
  assign fl_present = |fl_match;
  assign ht_match   = match(ht_tags, ht_vld, tag_of(ht_addr));
  assign ht_same    = ht_valid && (ht_idx == fl_idx);
  assign eff_flg    = fl_flg | (ht_same ? ht_match : '0);

  ic_recency #(.SETS(SETS), .WAYS(WAYS), .IDX_W(IDX_W), .WAY_W(WAY_W)) u_rec (
    .clk(clk), .rst_n(rst_n),
    .a_en(lk_found), .a_idx(s1_idx), .a_way(enc(lk_match)),
    .b_en(fl_valid), .b_idx(fl_idx), .b_way(touch_way),
    .q_idx(fl_idx), .lru_way(lru_way)
  );

  ic_victim_pick #(.WAYS(WAYS), .WAY_W(WAY_W)) u_vic (
    .vld(fl_vld), .flg(eff_flg), .lru_way(lru_way), .rnd_way(rnd_q[WAY_W-1:0]),
    .use_rand(ic_pol_e'(pol_rand) == POL_RAND),
    .way(vic_way), .by_hint(vic_by_hint), .evicts(vic_evicts)
  );

  assign wr_en         = fl_valid && !fl_present;
  assign touch_way     = fl_present ? enc(fl_match) : vic_way;
  assign evt_hint_repl = wr_en && vic_evicts && vic_by_hint;
  assign evt_base_repl = wr_en && vic_evicts && !vic_by_hint;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v <= 1'b0; s2_v <= 1'b0; s2_hit <= 1'b0;
      lk_done <= 1'b0; lk_hit <= 1'b0;
      s1_idx <= '0; s1_tag <= '0;
      rnd_q <= RND_SEED;
      cnt_hint_repl <= '0; cnt_base_repl <= '0;
    end else begin
      s1_v    <= lk_valid;
      s1_idx  <= idx_of(lk_addr);
      s1_tag  <= tag_of(lk_addr);
      s2_v    <= s1_v;
      s2_hit  <= lk_found;
      lk_done <= s2_v;
      lk_hit  <= s2_v && s2_hit;
      if (fl_valid)      rnd_q <= rnd_step(rnd_q);
      if (evt_hint_repl) cnt_hint_repl <= sat_inc(cnt_hint_repl);
      if (evt_base_repl) cnt_base_repl <= sat_inc(cnt_base_repl);
    end
  end
endmodule

// File: rtl/ic_hint_ctrl_chk.sv
`timescale 1ns/1ps
module ic_hint_ctrl_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic             lk_done,
  input logic             fl_valid,
  input logic             fl_present,
  input logic             evt_hint_repl,
  input logic             evt_base_repl,
  input logic [CNT_W-1:0] cnt_hint_repl,
  input logic [CNT_W-1:0] cnt_base_repl
);
  a_r2_done_due: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> ##3 lk_done);
  a_r2_no_stray_done: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> ##3 !lk_done);
  a_r4_one_source: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt_hint_repl, evt_base_repl}));
  a_r10_resident_no_evict: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_valid && fl_present) |-> !(evt_hint_repl || evt_base_repl));
  a_r8_still_without_fill: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_valid |=> ($stable(cnt_hint_repl) && $stable(cnt_base_repl)));
  a_r4_hint_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_hint_repl && !(&cnt_hint_repl)) |=> cnt_hint_repl == $past(cnt_hint_repl) + 1'b1);
  a_r8_base_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_base_repl && !(&cnt_base_repl)) |=> cnt_base_repl == $past(cnt_base_repl) + 1'b1);
  a_r8_hint_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (&cnt_hint_repl) |=> (&cnt_hint_repl));
  a_r8_base_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (&cnt_base_repl) |=> (&cnt_base_repl));
endmodule

bind ic_hint_ctrl ic_hint_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_done(lk_done),
  .fl_valid(fl_valid), .fl_present(fl_present),
  .evt_hint_repl(evt_hint_repl), .evt_base_repl(evt_base_repl),
  .cnt_hint_repl(cnt_hint_repl), .cnt_base_repl(cnt_base_repl)
);

// File: tb/ic_hint_ctrl_bench.sv
`timescale 1ns/1ps
module ic_hint_ctrl_bench;
  localparam int CW = 4;
  localparam int NS = 64;
  localparam int NW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pol_rand = 1'b0;
  logic lk_valid = 1'b0, fl_valid = 1'b0, ht_valid = 1'b0;
  logic [31:0] lk_addr = '0, fl_addr = '0, ht_addr = '0;
  logic lk_done, lk_hit;
  logic [CW-1:0] cnt_hint_repl, cnt_base_repl;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ic_hint_ctrl #(.CNT_W(CW)) u_ic_hint_ctrl (
    .clk(clk), .rst_n(rst_n), .pol_rand(pol_rand),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_done(lk_done), .lk_hit(lk_hit),
    .fl_valid(fl_valid), .fl_addr(fl_addr), .ht_valid(ht_valid), .ht_addr(ht_addr),
    .cnt_hint_repl(cnt_hint_repl), .cnt_base_repl(cnt_base_repl)
  );

  // reference model
  int          m_tag [NS][NW];
  bit          m_vld [NS][NW];
  bit          m_flg [NS][NW];
  longint      m_use [NS][NW];
  longint      m_now = 0;
  logic [15:0] m_rnd = 16'hACE1;
  int          m_ch = 0, m_cb = 0;

  function automatic logic [31:0] mk(int tag, int idx);
    return {20'(tag), 6'(idx), 6'($urandom % 64)};
  endfunction

  function automatic int m_find(int idx, int tag);
    for (int w = 0; w < NW; w++) if (m_vld[idx][w] && m_tag[idx][w] == tag) return w;
    return -1;
  endfunction

  function automatic int sat(int c);
    return (c >= (1 << CW) - 1) ? c : c + 1;
  endfunction

  function automatic void m_hint(int idx, int tag);
    int w = m_find(idx, tag);
    if (w >= 0) m_flg[idx][w] = 1'b1;
  endfunction

  function automatic void m_fill(int idx, int tag);
    int w = m_find(idx, tag);
    m_now++;
    if (w < 0) begin
      int v = -1;
      for (int i = NW-1; i >= 0; i--) if (!m_vld[idx][i]) v = i;
      if (v < 0) begin
        for (int i = NW-1; i >= 0; i--) if (m_flg[idx][i]) v = i;
        if (v >= 0) m_ch = sat(m_ch);
        else begin
          m_cb = sat(m_cb);
          if (pol_rand) v = int'(m_rnd[2:0]);
          else begin
            v = 0;
            for (int i = 1; i < NW; i++) if (m_use[idx][i] < m_use[idx][v]) v = i;
          end
        end
      end
      w = v;
      m_tag[idx][w] = tag; m_vld[idx][w] = 1'b1; m_flg[idx][w] = 1'b0;
    end
    m_use[idx][w] = m_now;
    m_rnd = (m_rnd << 1) | 16'(^(m_rnd & 16'hB400));
  endfunction

  task automatic check(string req, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic lookup(string req, int idx, int tag);
    int w;
    @(negedge clk); lk_valid = 1'b1; lk_addr = mk(tag, idx);
    @(negedge clk); lk_valid = 1'b0;
    @(negedge clk); check("R2", int'(lk_done), 0, "done early");
    @(negedge clk); check("R2", int'(lk_done), 1, "done at third edge");
    w = m_find(idx, tag);
    check(req, int'(lk_hit), int'(w >= 0), $sformatf("hit set %0d tag %0d", idx, tag));
    if (w >= 0) begin m_now++; m_use[idx][w] = m_now; end
  endtask

  // one cycle with any mix of fill and hint
  task automatic op(string req, bit fv, int fi, int ft, bit hv, int hi, int htg);
    @(negedge clk);
    fl_valid = fv; fl_addr = mk(ft, fi);
    ht_valid = hv; ht_addr = mk(htg, hi);
    @(negedge clk); fl_valid = 1'b0; ht_valid = 1'b0;
    if (hv) m_hint(hi, htg);
    if (fv) m_fill(fi, ft);
    check(req, int'(cnt_hint_repl), m_ch, "hint count");
    check(req, int'(cnt_base_repl), m_cb, "base count");
  endtask

  task automatic fill(string req, int idx, int tag);
    op(req, 1'b1, idx, tag, 1'b0, 0, 0);
  endtask
  task automatic hint(string req, int idx, int tag);
    op(req, 1'b0, 0, 0, 1'b1, idx, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) begin
        m_vld[s][w] = 0; m_flg[s][w] = 0; m_use[s][w] = 0; m_tag[s][w] = 0;
      end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11", int'(lk_done), 0, "done after reset");
    check("R11", int'(cnt_hint_repl), 0, "hint count after reset");
    check("R11", int'(cnt_base_repl), 0, "base count after reset");
    lookup("R11", 5, 3);
    // R3 fill invalid ways, R1 hits
    for (int t = 0; t < 8; t++) fill("R3", 5, 10 + t);
    for (int t = 0; t < 8; t++) lookup("R1", 5, 10 + t);
    lookup("R1", 6, 10);
    lookup("R1", 5, 99);
    // R6 LRU: tag 10 touched again, tag 11 oldest
    lookup("R6", 5, 10);
    fill("R6", 5, 40);
    lookup("R6", 5, 11);
    lookup("R6", 5, 10);
    // R10 resident fill refreshes only
    fill("R10", 5, 12);
    // R5 absent hint
    hint("R5", 5, 77);
    fill("R5", 5, 41);
    lookup("R5", 5, 13);
    // R4 two hinted lines, lowest way wins, mark survives a hit
    hint("R4", 5, 16);
    hint("R4", 5, 14);
    lookup("R4", 5, 16);
    fill("R4", 5, 42);
    lookup("R4", 5, 14);
    fill("R4", 5, 43);
    lookup("R4", 5, 16);
    // R9 same-cycle hint and fill
    op("R9", 1'b1, 5, 44, 1'b1, 5, 17);
    lookup("R9", 5, 17);
    // R7 random policy
    pol_rand = 1'b1;
    for (int t = 0; t < 12; t++) fill("R7", 9, 200 + t);
    for (int t = 0; t < 12; t++) lookup("R7", 9, 200 + t);
    // R8 saturation of both counters
    for (int t = 0; t < 24; t++) fill("R8", 20, 300 + t);
    for (int t = 0; t < 8; t++) fill("R8", 21, 400 + t);
    for (int t = 0; t < 20; t++) begin
      hint("R8", 21, 400 + (t % 8));
      fill("R8", 21, 500 + t);
    end
    // random phase
    for (int i = 0; i < 1500; i++) begin
      int r = $urandom % 100;
      int si = $urandom % 4;
      int tg = $urandom % 12;
      if (i % 300 == 0) pol_rand = ~pol_rand;
      if (r < 40)      lookup("R1", si, tg);
      else if (r < 70) fill("R6", si, tg);
      else if (r < 85) hint("R4", si, tg);
      else             op("R9", 1'b1, si, tg, 1'b1, si, $urandom % 12);
    end
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule